// File: doc/BRIEF.md
# Real-Mode Software Interrupt Entry Sequencer

This block carries out the entry sequence of a software interrupt for a processor running in real-address mode. A one-cycle start pulse hands it an 8-bit vector number together with the current flags, the current code selector, the code-segment limit and the address of the following instruction. It captures all of these and then reads the two halves of the vector's 4-byte table entry over a 16-bit read port. Next it pushes three words through a 16-bit write port. Stack-pointer arithmetic stays with whatever sits behind that port.

After the pushes, the block compares the fetched handler offset with the code-segment limit. If the offset does not exceed the limit, the transfer completes. The block loads the new code selector, the code base (the selector multiplied by sixteen) and the new instruction pointer. It also loads a copy of the flags with the trap, interrupt-enable, resume and alignment-check bits cleared. If the offset is above the limit, the block signals a general-protection fault and leaves every architectural output as it was. Each memory request is held until the memory answers with a single-cycle ready. Start pulses that arrive while a sequence is running are ignored.

Top module: `rm_irq_dispatch`

## Requirements
- R1: After reset, busy_o, done_o and fault_o are low, and cs_sel_o, cs_base_o, ip_o and flags_o are all zero.
- R2: The block issues exactly two reads. The first is at byte address vector*4 and returns the handler offset. The second is at vector*4+2 and returns the handler selector. The vector is zero-extended and rd_addr_o is 10 bits wide. Each request, with its address, stays asserted until rd_ready_i is sampled high.
- R3: The block issues exactly three writes, one word per accepted wr_ready_i, in this order: flags_i bits 15:0, then the old code selector, then the next-instruction address. Each write request and its data stay stable until accepted, and reads and writes never overlap.
- R4: A fault is reported exactly when the fetched offset is strictly greater than cs_limit_i. An offset equal to the limit completes normally. fault_o is only high together with done_o.
- R5: On success, cs_sel_o equals the fetched selector and cs_base_o (20 bits) equals that selector shifted left by 4.
- R6: On success, ip_o equals the fetched offset. flags_o equals the captured flags_i with bits 8, 9, 16 and 18 cleared and every other bit unchanged.
- R7: On a fault, cs_sel_o, cs_base_o, ip_o and flags_o keep the values they had before the sequence.
- R8: A start pulse while busy_o is high has no effect on addresses, pushed data or results, and issues no further sequence. With busy_o low, no memory request is driven.
- R9: busy_o rises in the cycle after start_i is sampled. done_o is a one-cycle pulse, and busy_o is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a dispatch (one-cycle pulse) |
| vector_i | input | 8 | Interrupt vector number |
| flags_i | input | 32 | Current flags |
| cs_sel_i | input | 16 | Current code selector |
| cs_limit_i | input | 16 | Code-segment limit |
| next_ip_i | input | 16 | Address of the following instruction |
| rd_req_o | output | 1 | Table read request |
| rd_addr_o | output | 10 | Table byte address |
| rd_ready_i | input | 1 | Read completion, one cycle |
| rd_data_i | input | 16 | Read data, valid with rd_ready_i |
| wr_req_o | output | 1 | Stack push request |
| wr_data_o | output | 16 | Word to push |
| wr_ready_i | input | 1 | Push completion, one cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (pulse) |
| fault_o | output | 1 | General-protection fault, with done_o |
| cs_sel_o | output | 16 | Code selector result |
| cs_base_o | output | 20 | Code base result |
| ip_o | output | 16 | Instruction pointer result |
| flags_o | output | 32 | Flags result |

## Verification
The hardest situation to reach from the ports is a start pulse landing in the middle of a sequence while a memory handshake is stalled. For it to say anything, that pulse must carry a vector and operands that differ from the running ones. The stimulus gives the memory responder a random latency of zero to three cycles per access. It then injects a second start with inverted vector and different operands a few cycles into many dispatches. The expected reads, pushes and results must still match the first request. The limit boundary is driven directly, with the offset equal to the limit and one above it, and a fault is followed by a success to show that the held outputs were really retained.

// File: rtl/rmid_pkg.sv
package rmid_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_IP,
        ST_RD_CS,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_CHECK,
        ST_FINISH
    } state_t;

    // flag bit positions cleared on entry
    localparam int unsigned BIT_TRAP   = 8;
    localparam int unsigned BIT_INTEN  = 9;
    localparam int unsigned BIT_RESUME = 16;
    localparam int unsigned BIT_ALIGN  = 18;

    // selector to base conversion
    localparam int unsigned SEG_SHIFT = 4;
endpackage

// File: rtl/rmid_vec_addr.sv
module rmid_vec_addr #(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic             hi_half_i,
    output logic [VEC_W+1:0] addr_o
);
    // four bytes per entry; offset half at +0, selector half at +2
    assign addr_o = {vec_i, hi_half_i, 1'b0};
endmodule

// File: rtl/rmid_commit.sv
module rmid_commit
    import rmid_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int FLAG_W = 32
) (
    input  logic [WORD_W-1:0]           tgt_ip_i,
    input  logic [WORD_W-1:0]           tgt_cs_i,
    input  logic [WORD_W-1:0]           limit_i,
    input  logic [FLAG_W-1:0]           flags_i,
    output logic                        fault_o,
    output logic [WORD_W+SEG_SHIFT-1:0] base_o,
    output logic [FLAG_W-1:0]           flags_o
);
    localparam logic [FLAG_W-1:0] CLR_MASK = (FLAG_W'(1) << BIT_TRAP)
                                           | (FLAG_W'(1) << BIT_INTEN)
                                           | (FLAG_W'(1) << BIT_RESUME)
                                           | (FLAG_W'(1) << BIT_ALIGN);

    assign fault_o = tgt_ip_i > limit_i;
    assign base_o  = {tgt_cs_i, {SEG_SHIFT{1'b0}}};
    assign flags_o = flags_i & ~CLR_MASK;
endmodule

// File: rtl/rm_irq_dispatch.sv
module rm_irq_dispatch
    import rmid_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 16,
    parameter int FLAG_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [VEC_W-1:0]            vector_i,
    input  logic [FLAG_W-1:0]           flags_i,
    input  logic [WORD_W-1:0]           cs_sel_i,
    input  logic [WORD_W-1:0]           cs_limit_i,
    input  logic [WORD_W-1:0]           next_ip_i,
    output logic                        rd_req_o,
    output logic [VEC_W+1:0]            rd_addr_o,
    input  logic                        rd_ready_i,
    input  logic [WORD_W-1:0]           rd_data_i,
    output logic                        wr_req_o,
    output logic [WORD_W-1:0]           wr_data_o,
    input  logic                        wr_ready_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        fault_o,
    output logic [WORD_W-1:0]           cs_sel_o,
    output logic [WORD_W+SEG_SHIFT-1:0] cs_base_o,
    output logic [WORD_W-1:0]           ip_o,
    output logic [FLAG_W-1:0]           flags_o
);
    localparam int BASE_W = WORD_W + SEG_SHIFT;

    typedef struct packed {
        state_t              st;
        logic [VEC_W-1:0]    vec;
        logic [FLAG_W-1:0]   flags;
        logic [WORD_W-1:0]   cs_old;
        logic [WORD_W-1:0]   limit;
        logic [WORD_W-1:0]   nip;
        logic [WORD_W-1:0]   tip;
        logic [WORD_W-1:0]   tcs;
        logic                fault;
        logic [WORD_W-1:0]   arch_cs;
        logic [BASE_W-1:0]   arch_base;
        logic [WORD_W-1:0]   arch_ip;
        logic [FLAG_W-1:0]   arch_flags;
    } regs_t;

    regs_t q, d;

    logic              cmt_fault;
    logic [BASE_W-1:0] cmt_base;
    logic [FLAG_W-1:0] cmt_flags;

    rmid_vec_addr #(.VEC_W(VEC_W)) u_addr (
        .vec_i     (q.vec),
        .hi_half_i (q.st == ST_RD_CS),
        .addr_o    (rd_addr_o)
    );

    rmid_commit #(.WORD_W(WORD_W), .FLAG_W(FLAG_W)) u_commit (
        .tgt_ip_i (q.tip),
        .tgt_cs_i (q.tcs),
        .limit_i  (q.limit),
        .flags_i  (q.flags),
        .fault_o  (cmt_fault),
        .base_o   (cmt_base),
        .flags_o  (cmt_flags)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_RD_IP;
                    d.vec    = vector_i;
                    d.flags  = flags_i;
                    d.cs_old = cs_sel_i;
                    d.limit  = cs_limit_i;
                    d.nip    = next_ip_i;
                    d.fault  = 1'b0;
                end
            end
            ST_RD_IP: begin
                if (rd_ready_i) begin
                    d.tip = rd_data_i;
                    d.st  = ST_RD_CS;
                end
            end
            ST_RD_CS: begin
                if (rd_ready_i) begin
                    d.tcs = rd_data_i;
                    d.st  = ST_PUSH_FL;
                end
            end
            ST_PUSH_FL: if (wr_ready_i) d.st = ST_PUSH_CS;
            ST_PUSH_CS: if (wr_ready_i) d.st = ST_PUSH_IP;
            ST_PUSH_IP: if (wr_ready_i) d.st = ST_CHECK;
            ST_CHECK: begin
                d.fault = cmt_fault;
                if (!cmt_fault) begin
                    d.arch_cs    = q.tcs;
                    d.arch_base  = cmt_base;
                    d.arch_ip    = q.tip;
                    d.arch_flags = cmt_flags;
                end
                d.st = ST_FINISH;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        case (q.st)
            ST_PUSH_FL: wr_data_o = q.flags[WORD_W-1:0];
            ST_PUSH_CS: wr_data_o = q.cs_old;
            ST_PUSH_IP: wr_data_o = q.nip;
            default:    wr_data_o = '0;
        endcase
    end

    assign rd_req_o  = (q.st == ST_RD_IP) || (q.st == ST_RD_CS);
    assign wr_req_o  = (q.st == ST_PUSH_FL) || (q.st == ST_PUSH_CS) || (q.st == ST_PUSH_IP);
    assign busy_o    = q.st != ST_IDLE;
    assign done_o    = q.st == ST_FINISH;
    assign fault_o   = done_o && q.fault;
    assign cs_sel_o  = q.arch_cs;
    assign cs_base_o = q.arch_base;
    assign ip_o      = q.arch_ip;
    assign flags_o   = q.arch_flags;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= regs_t'('0);
        else        q <= d;
    end
endmodule

// File: rtl/rmid_chk.sv
module rmid_chk
    import rmid_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 16,
    parameter int FLAG_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        rd_req_o,
    input logic [VEC_W+1:0]            rd_addr_o,
    input logic                        rd_ready_i,
    input logic                        wr_req_o,
    input logic [WORD_W-1:0]           wr_data_o,
    input logic                        wr_ready_i,
    input logic                        busy_o,
    input logic                        done_o,
    input logic                        fault_o,
    input logic [WORD_W-1:0]           cs_sel_o,
    input logic [WORD_W+SEG_SHIFT-1:0] cs_base_o,
    input logic [WORD_W-1:0]           ip_o,
    input logic [FLAG_W-1:0]           flags_o
);
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ready_i |=> rd_req_o && $stable(rd_addr_o));
    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ready_i |=> wr_req_o && $stable(wr_data_o));
    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));
    // R4
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);
    // R5
    base_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o |-> cs_base_o == {cs_sel_o, {SEG_SHIFT{1'b0}}});
    // R6
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o |-> !flags_o[BIT_TRAP] && !flags_o[BIT_INTEN]
                               && !flags_o[BIT_RESUME] && !flags_o[BIT_ALIGN]);
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o |-> $stable(cs_sel_o) && $stable(cs_base_o)
                              && $stable(ip_o) && $stable(flags_o));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !wr_req_o);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind rm_irq_dispatch rmid_chk #(.VEC_W(VEC_W), .WORD_W(WORD_W), .FLAG_W(FLAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ready_i (rd_ready_i),
    .wr_req_o   (wr_req_o),
    .wr_data_o  (wr_data_o),
    .wr_ready_i (wr_ready_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .cs_sel_o   (cs_sel_o),
    .cs_base_o  (cs_base_o),
    .ip_o       (ip_o),
    .flags_o    (flags_o)
);

// File: tb/tb_rm_irq_dispatch.sv
module tb_rm_irq_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  vector_i = '0;
    logic [31:0] flags_i = '0;
    logic [15:0] cs_sel_i = '0, cs_limit_i = '0, next_ip_i = '0;
    logic        rd_req_o, rd_ready_i, wr_req_o, wr_ready_i;
    logic [9:0]  rd_addr_o;
    logic [15:0] rd_data_i, wr_data_o;
    logic        busy_o, done_o, fault_o;
    logic [15:0] cs_sel_o, ip_o;
    logic [19:0] cs_base_o;
    logic [31:0] flags_o;

    rm_irq_dispatch dut (.*);

    always #2ns clk = ~clk;

    int checks = 0, errors = 0;
    logic [15:0] ip_tab [256];
    logic [15:0] cs_tab [256];
    logic [9:0]  rd_log [8];
    logic [15:0] wr_log [8];
    int rd_n, wr_n, rd_cnt, wr_cnt;
    logic [15:0] m_cs = '0, m_ip = '0;
    logic [19:0] m_base = '0;
    logic [31:0] m_flags = '0;

    localparam logic [31:0] CLR = 32'h0005_0300;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // memory responder with random latency
    initial begin
        rd_ready_i = 0; wr_ready_i = 0; rd_data_i = '0;
        rd_cnt = 0; wr_cnt = 0; rd_n = 0; wr_n = 0;
        forever begin
            @(negedge clk);
            rd_ready_i = 0;
            wr_ready_i = 0;
            if (rd_req_o) begin
                if (rd_cnt == 0) begin
                    rd_ready_i = 1;
                    rd_data_i = rd_addr_o[1] ? cs_tab[rd_addr_o[9:2]] : ip_tab[rd_addr_o[9:2]];
                    if (rd_n < 8) rd_log[rd_n] = rd_addr_o;
                    rd_n++;
                    rd_cnt = int'($urandom % 4);
                end else rd_cnt--;
            end
            if (wr_req_o) begin
                if (wr_cnt == 0) begin
                    wr_ready_i = 1;
                    if (wr_n < 8) wr_log[wr_n] = wr_data_o;
                    wr_n++;
                    wr_cnt = int'($urandom % 4);
                end else wr_cnt--;
            end
        end
    end

    task automatic dispatch(input logic [7:0] v, input logic [31:0] fl, input logic [15:0] cs,
                            input logic [15:0] lim, input logic [15:0] nip, input bit intrude);
        logic [15:0] tip, tcs;
        bit exp_fault, seen;
        tip = ip_tab[v];
        tcs = cs_tab[v];
        exp_fault = tip > lim;
        seen = 0;
        @(negedge clk);
        rd_n = 0; wr_n = 0;
        vector_i = v; flags_i = fl; cs_sel_i = cs; cs_limit_i = lim; next_ip_i = nip;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(busy_o, "R9 busy after start", busy_o, 1);
        for (int k = 0; k < 300; k++) begin
            if (done_o) begin seen = 1; break; end
            if (intrude && k == 2) begin
                start_i = 1; vector_i = ~v; flags_i = ~fl; cs_sel_i = ~cs;
                cs_limit_i = ~lim; next_ip_i = ~nip;
            end else start_i = 0;
            @(negedge clk);
        end
        start_i = 0;
        chk(seen, "R9 done reached", seen, 1);
        if (!seen) return;
        chk(rd_n == 2, "R2 read count", rd_n, 2);
        chk(rd_log[0] == {v, 2'b00} && rd_log[1] == {v, 2'b10}, "R2 read addresses",
            {rd_log[0], rd_log[1]}, {v, 2'b00, v, 2'b10});
        chk(wr_n == 3, "R3 push count", wr_n, 3);
        chk(wr_log[0] == fl[15:0] && wr_log[1] == cs && wr_log[2] == nip, "R3 push order",
            {wr_log[0], wr_log[1], wr_log[2]}, {fl[15:0], cs, nip});
        chk(fault_o == exp_fault, "R4 fault decision", fault_o, exp_fault);
        if (!exp_fault) begin
            m_cs = tcs; m_base = {tcs, 4'h0}; m_ip = tip; m_flags = fl & ~CLR;
        end
        chk(cs_sel_o == m_cs && cs_base_o == m_base,
            exp_fault ? "R7 selector held" : "R5 selector and base",
            {cs_sel_o, cs_base_o}, {m_cs, m_base});
        chk(ip_o == m_ip && flags_o == m_flags,
            exp_fault ? "R7 ip and flags held" : "R6 ip and flags",
            {ip_o, flags_o}, {m_ip, m_flags});
        @(negedge clk);
        chk(!done_o && !busy_o, "R8 R9 idle after done, no retrigger", {done_o, busy_o}, 0);
        chk(rd_n == 2 && wr_n == 3, "R8 no extra traffic", {rd_n, wr_n}, {32'd2, 32'd3});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) begin
            ip_tab[i] = 16'($urandom);
            cs_tab[i] = 16'($urandom);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !fault_o, "R1 control reset", {busy_o, done_o, fault_o}, 0);
        chk(cs_sel_o == 0 && cs_base_o == 0 && ip_o == 0 && flags_o == 0, "R1 outputs reset",
            {cs_sel_o, cs_base_o, ip_o, flags_o}, 0);
        // R4 boundary: equal passes
        ip_tab[0] = 16'h1234; cs_tab[0] = 16'hf00d;
        dispatch(8'h00, 32'h0000_0202, 16'h0100, 16'h1234, 16'h0042, 0);
        // R4 R7: one above faults
        ip_tab[255] = 16'h1235; cs_tab[255] = 16'h0bad;
        dispatch(8'hff, 32'hffff_ffff, 16'h2222, 16'h1234, 16'h3333, 0);
        // R6 all flags set, max limit
        dispatch(8'h40, 32'hffff_ffff, 16'h4444, 16'hffff, 16'h5555, 0);
        // R8 intrusion
        dispatch(8'h81, 32'h0001_0100, 16'h7777, 16'hffff, 16'h8888, 1);
        // R4 zero limit with nonzero offset
        ip_tab[3] = 16'h0001;
        dispatch(8'h03, 32'h1234_5678, 16'h9999, 16'h0000, 16'haaaa, 1);
        for (int n = 0; n < 40; n++) begin
            dispatch(8'($urandom), $urandom, 16'($urandom), 16'($urandom),
                     16'($urandom), bit'($urandom % 2));
        end
        summary();
        $finish;
    end
endmodule